// File: doc/BRIEF.md
# GPIO Bank with Interrupt Capture

This block is a bank of general-purpose pins, 32 wide by default, controlled through a small memory-mapped register port. Each pin has an output value and a drive-enable bit. Both can be written as a whole word, or changed bit by bit through write-one set and clear aliases. That way software can flip single pins without a read-modify-write. Pin levels come in through a two-flop synchronizer and can be read back as an input word.

Every pin also has an event detector. A mode bit chooses between edge and level sensing. A polarity bit chooses between active-high (rising edge) and active-low (falling edge). In edge mode, a second control bit makes the pin fire on any edge, and the polarity bit is then ignored. Detected events are held in a capture word that software clears by writing ones. Each pin has its own enable, set and cleared through a pair of aliases. A single interrupt line is raised while any enabled pin has a pending capture.

The register port is a plain single-cycle control interface with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` follows `reg_addr` combinationally.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_out` and `pin_oe` are 0, and `irq` is 0.
- R2: Whole-word writes to output (0x00), direction (0x08), polarity (0x18), any-edge (0x1C) and mode (0x2C) are read back unchanged at the same offset. Unmapped offsets read 0.
- R3: A write to 0x40 sets the output bits where the data is 1. A write to 0x44 clears them. All other bits keep their value. Both offsets read back the output register.
- R4: A write to 0x48 sets the direction bits where the data is 1. A write to 0x4C clears them. All other bits keep their value. Both offsets read back the direction register.
- R5: A write to 0x30 sets interrupt enable bits and a write to 0x34 clears them. Both offsets read back the enable word.
- R6: Offset 0x04 returns `pin_in` delayed by two clock edges.
- R7: In edge mode (mode bit 0) with polarity 0 and any-edge 0, a rising synchronized input sets the pin's capture bit (0x20) at the third edge after the pin changes. A falling input does not.
- R8: In edge mode with polarity 1 and any-edge 0, only a falling input sets the capture bit.
- R9: In edge mode with any-edge 1, both rising and falling inputs set the capture bit, whatever the polarity bit is.
- R10: In level mode (mode bit 1), the capture bit is set on every cycle while the synchronized input equals the active level: high for polarity 0, low for polarity 1. A clear written while that level persists has no lasting effect.
- R11: Writing ones to 0x20 clears those capture bits. Zero bits leave their captures pending. An event in the same cycle as a clear wins.
- R12: `irq` is 1 exactly when some pin has both its capture and enable bits set. Events are captured even on disabled pins.
- R13: `pin_out` equals the output register and `pin_oe` equals the direction register (1 = drive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW (7) | Byte offset of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NPIN (32) | Pad input levels, asynchronous |
| pin_out | output | NPIN (32) | Output values |
| pin_oe | output | NPIN (32) | Output drive enables |
| irq | output | 1 | Combined interrupt |

## Verification
The results fall due at different times:
- Register writes are visible on `reg_rdata`, `pin_out` and `pin_oe` one edge after the write.
- The input word lags `pin_in` by two edges.
- A capture bit, and with it `irq`, lags the pin by three edges.

The bench drives everything on falling edges. It checks the input word exactly one and two edges after a change, so the two-flop delay is pinned down. For captures, it waits four edges before reading, which leaves a margin past the three-edge latency.

// File: rtl/gio_pkg.sv
package gio_pkg;
  localparam int unsigned DW = 32;
  localparam logic [6:0] OFF_OUT   = 7'h00;
  localparam logic [6:0] OFF_IN    = 7'h04;
  localparam logic [6:0] OFF_DIR   = 7'h08;
  localparam logic [6:0] OFF_POL   = 7'h18;
  localparam logic [6:0] OFF_ANY   = 7'h1C;
  localparam logic [6:0] OFF_CAP   = 7'h20;
  localparam logic [6:0] OFF_MODE  = 7'h2C;
  localparam logic [6:0] OFF_ENSET = 7'h30;
  localparam logic [6:0] OFF_ENCLR = 7'h34;
  localparam logic [6:0] OFF_OSET  = 7'h40;
  localparam logic [6:0] OFF_OCLR  = 7'h44;
  localparam logic [6:0] OFF_DSET  = 7'h48;
  localparam logic [6:0] OFF_DCLR  = 7'h4C;
endpackage

// File: rtl/gio_sync.sv
module gio_sync #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] raw,
  output logic [NPIN-1:0] smp,
  output logic [NPIN-1:0] smp_prev
);
  logic [NPIN-1:0] meta_q;

  // two flops to resolve metastability, then one more for edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      smp      <= '0;
      smp_prev <= '0;
    end else begin
      meta_q   <= raw;
      smp      <= meta_q;
      smp_prev <= smp;
    end
  end
endmodule

// File: rtl/gio_event.sv
module gio_event #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] smp,
  input  logic [NPIN-1:0] smp_prev,
  input  logic [NPIN-1:0] lvl_mode,
  input  logic [NPIN-1:0] neg_pol,
  input  logic [NPIN-1:0] any_edge,
  output logic [NPIN-1:0] hit
);
  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      logic rise, fall, active;
      assign rise   = smp[g] & ~smp_prev[g];
      assign fall   = ~smp[g] & smp_prev[g];
      assign active = smp[g] ^ neg_pol[g];
      always_comb begin
        if (lvl_mode[g])      hit[g] = active;
        else if (any_edge[g]) hit[g] = rise | fall;
        else if (neg_pol[g])  hit[g] = fall;
        else                  hit[g] = rise;
      end
    end
  endgenerate
endmodule

// File: rtl/gio_capture.sv
module gio_capture #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] hit,
  input  logic [NPIN-1:0] clr,
  input  logic [NPIN-1:0] en,
  output logic [NPIN-1:0] cap,
  output logic            irq
);
  // a new event outranks a clear landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else        cap <= (cap & ~clr) | hit;
  end

  assign irq = |(cap & en);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gio_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  logic [NPIN-1:0] out_q, dir_q, pol_q, any_q, mode_q, en_q;
  logic [NPIN-1:0] smp, smp_prev, hit, cap, clr;
  logic [NPIN-1:0] wd;

  assign wd = reg_wdata[NPIN-1:0];

  function automatic logic hit_off(input logic [AW-1:0] a, input logic [6:0] off);
    return reg_wr && (a == AW'(off));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      mode_q <= '0;
      en_q   <= '0;
    end else begin
      if (hit_off(reg_addr, OFF_OUT))   out_q  <= wd;
      if (hit_off(reg_addr, OFF_OSET))  out_q  <= out_q | wd;
      if (hit_off(reg_addr, OFF_OCLR))  out_q  <= out_q & ~wd;
      if (hit_off(reg_addr, OFF_DIR))   dir_q  <= wd;
      if (hit_off(reg_addr, OFF_DSET))  dir_q  <= dir_q | wd;
      if (hit_off(reg_addr, OFF_DCLR))  dir_q  <= dir_q & ~wd;
      if (hit_off(reg_addr, OFF_POL))   pol_q  <= wd;
      if (hit_off(reg_addr, OFF_ANY))   any_q  <= wd;
      if (hit_off(reg_addr, OFF_MODE))  mode_q <= wd;
      if (hit_off(reg_addr, OFF_ENSET)) en_q   <= en_q | wd;
      if (hit_off(reg_addr, OFF_ENCLR)) en_q   <= en_q & ~wd;
    end
  end

  assign clr = hit_off(reg_addr, OFF_CAP) ? wd : '0;

  gio_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .smp(smp), .smp_prev(smp_prev)
  );

  gio_event #(.NPIN(NPIN)) u_event (
    .smp(smp), .smp_prev(smp_prev), .lvl_mode(mode_q), .neg_pol(pol_q),
    .any_edge(any_q), .hit(hit)
  );

  gio_capture #(.NPIN(NPIN)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .en(en_q),
    .cap(cap), .irq(irq)
  );

  always_comb begin
    unique case (reg_addr)
      AW'(OFF_OUT), AW'(OFF_OSET), AW'(OFF_OCLR): reg_rdata = DW'(out_q);
      AW'(OFF_DIR), AW'(OFF_DSET), AW'(OFF_DCLR): reg_rdata = DW'(dir_q);
      AW'(OFF_ENSET), AW'(OFF_ENCLR):             reg_rdata = DW'(en_q);
      AW'(OFF_IN):                                reg_rdata = DW'(smp);
      AW'(OFF_POL):                               reg_rdata = DW'(pol_q);
      AW'(OFF_ANY):                               reg_rdata = DW'(any_q);
      AW'(OFF_MODE):                              reg_rdata = DW'(mode_q);
      AW'(OFF_CAP):                               reg_rdata = DW'(cap);
      default:                                    reg_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gio_checker.sv
module gio_checker
  import gio_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_wr,
  input logic [31:0]     reg_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] en,
  input logic            irq
);
  // R1: one edge inside reset leaves outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq));

  // R3: output set / clear aliases
  a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_OSET)) |=>
      ((pin_out & $past(reg_wdata[NPIN-1:0])) == $past(reg_wdata[NPIN-1:0])));
  a_r3_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_OCLR)) |=>
      ((pin_out & $past(reg_wdata[NPIN-1:0])) == '0));

  // R4: direction set / clear aliases
  a_r4_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_DSET)) |=>
      ((pin_oe & $past(reg_wdata[NPIN-1:0])) == $past(reg_wdata[NPIN-1:0])));
  a_r4_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_DCLR)) |=>
      ((pin_oe & $past(reg_wdata[NPIN-1:0])) == '0));

  // R5: enable clear alias
  a_r5_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_ENCLR)) |=>
      ((en & $past(reg_wdata[NPIN-1:0])) == '0));

  // R12: no interrupt without an enabled pin
  a_r12_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind gpio_irq_bank gio_checker #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .en(en_q),
  .irq(irq)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 32;

  localparam logic [6:0] A_OUT = 7'h00, A_IN = 7'h04, A_DIR = 7'h08,
    A_POL = 7'h18, A_ANY = 7'h1C, A_CAP = 7'h20, A_MODE = 7'h2C,
    A_ENS = 7'h30, A_ENC = 7'h34, A_OS = 7'h40, A_OC = 7'h44,
    A_DS = 7'h48, A_DC = 7'h4C;

  logic clk = 0, rst_n = 0, reg_wr = 0, irq;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NPIN-1:0] pin_in = '0, pin_out, pin_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NPIN(NPIN), .AW(7)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] o, dd, e;
    tick(3);
    // R1 reset state on all offsets
    for (int k = 0; k < 20; k++) rdchk("R1 reset read", 7'(k*4), 32'h0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1;
    tick(2);

    // R2 whole-word readback
    wr(A_OUT, 32'hA5A5_0F0F); rdchk("R2 out", A_OUT, 32'hA5A5_0F0F);
    wr(A_DIR, 32'h1234_5678); rdchk("R2 dir", A_DIR, 32'h1234_5678);
    wr(A_POL, 32'hDEAD_BEEF); rdchk("R2 pol", A_POL, 32'hDEAD_BEEF);
    wr(A_ANY, 32'h0BAD_F00D); rdchk("R2 any", A_ANY, 32'h0BAD_F00D);
    wr(A_MODE, 32'hCAFE_0001); rdchk("R2 mode", A_MODE, 32'hCAFE_0001);
    rdchk("R2 unmapped", 7'h10, 0);
    rdchk("R13 pin_out", A_OUT, pin_out);
    check("R13 pin_oe", pin_oe, 32'h1234_5678);
    wr(A_POL, 0); wr(A_ANY, 0); wr(A_MODE, 0);
    tick(4); wr(A_CAP, '1);

    // R3 / R4 / R5 alias sweeps with arithmetic model
    o = 32'hA5A5_0F0F; dd = 32'h1234_5678; e = 0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] s, c;
      s = 32'h1 << k | 32'h0101_0000 << (k % 8);
      c = 32'h8000_0000 >> k | 32'h0000_00F0 << (k % 4);
      wr(A_OS, s); o |= s;   rdchk("R3 out set", A_OS, o);
      wr(A_OC, c); o &= ~c;  rdchk("R3 out clr", A_OC, o);
      check("R13 pin_out", pin_out, o);
      wr(A_DS, c); dd |= c;  rdchk("R4 dir set", A_DS, dd);
      wr(A_DC, s); dd &= ~s; rdchk("R4 dir clr", A_DC, dd);
      check("R13 pin_oe", pin_oe, dd);
      wr(A_ENS, s); e |= s;  rdchk("R5 en set", A_ENS, e);
      wr(A_ENC, c); e &= ~c; rdchk("R5 en clr", A_ENC, e);
    end
    wr(A_ENC, '1);

    // R6 two-edge input lag
    for (int k = 0; k < 4; k++) begin
      logic [31:0] pv, nv;
      pv = pin_in;
      nv = 32'h9E37_79B9 * (k + 1);
      pin_in = nv;
      tick(1); rdchk("R6 after 1 edge", A_IN, pv);
      tick(1); rdchk("R6 after 2 edges", A_IN, nv);
    end
    pin_in = 0; tick(4); wr(A_CAP, '1);

    // R7-R10, R12: sweep all pins, each with one of 8 trigger configs
    for (int p = 0; p < NPIN; p++) begin
      for (int v0 = 0; v0 < 2; v0++) begin
        logic lvl, neg, any, v1, ec, et;
        logic [31:0] bit_p, d;
        lvl = p[0]; neg = p[1]; any = p[2];
        v1 = ~v0[0];
        bit_p = 32'h1 << p;
        wr(A_MODE, 0); wr(A_POL, 0); wr(A_ANY, 0); wr(A_ENC, '1);
        pin_in = 0; tick(4); wr(A_CAP, '1);
        wr(A_MODE, lvl ? bit_p : 0);
        wr(A_POL, neg ? bit_p : 0);
        wr(A_ANY, any ? bit_p : 0);
        pin_in[p] = v0[0];
        tick(4);
        wr(A_CAP, '1);
        ec = lvl && (v0[0] != neg);
        rd(A_CAP, d);
        check(lvl ? "R10 clear while level held" : "R11 clear edge capture", d, ec ? bit_p : 0);
        if (v0 == 0) wr(A_ENS, bit_p);
        pin_in[p] = v1;
        tick(4);
        if (lvl)       et = 1;
        else if (any)  et = 1;
        else if (neg)  et = ~v1;
        else           et = v1;
        rd(A_CAP, d);
        check(lvl ? "R10 level capture" : any ? "R9 any edge" : neg ? "R8 falling" : "R7 rising",
              d, et ? bit_p : 0);
        check("R12 irq", 32'(irq), 32'(et && v0 == 0));
      end
    end

    // R11 partial clear keeps other captures; event beats clear
    wr(A_MODE, 0); wr(A_POL, 0); wr(A_ANY, 0); wr(A_ENC, '1);
    pin_in = 0; tick(4); wr(A_CAP, '1);
    pin_in = 32'h0000_0011; tick(4);
    rdchk("R11 two captured", A_CAP, 32'h11);
    wr(A_CAP, 32'h1);
    rdchk("R11 zero bit kept", A_CAP, 32'h10);
    wr(A_ENS, 32'h10);
    check("R12 irq pending", 32'(irq), 1);
    wr(A_CAP, 32'h10);
    check("R12 irq cleared", 32'(irq), 0);
    // event lands at the edge of the clear: pin changes 3 edges before write edge
    pin_in = 32'h0000_0111; tick(2);
    wr(A_CAP, 32'h100);
    rdchk("R11 event wins over clear", A_CAP, 32'h100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule